// File: doc/BRIEF.md
# Interrupt Acknowledge Sequencer

This block sits in front of the instruction sequencer of a small 8-bit processor core and makes the interrupt decision at each instruction boundary. The core marks a boundary with a one-cycle strobe. At that strobe the block looks at a latched non-maskable request, the level of the maskable request line, the two interrupt-enable flip-flops it owns, and the last instruction the core executed. It then picks at most one request and runs the matching acknowledge.

A response is handed back as a one-cycle `resp_valid` pulse. With it come the jump target (which also serves as the core's MEMPTR value), the return address to push, the number of T-states to charge, a refresh-counter increment, and the strobes that drop the HALT state or clear the parity/overflow flag. For vectored mode 2 the block first issues a single-cycle table read to the core's memory port and takes the 16-bit target back on the next clock edge.

The block also holds the enable flip-flops and the interrupt-mode state. The core updates them through a small command input when it executes the enable, disable, return-from-NMI or mode-select instructions.

Top module: `irq_ack_seq`

## Requirements
- R1: A falling edge on `nmi_n`, seen between two rising clock edges, latches one non-maskable request. That request stays pending until a boundary accepts it and is then serviced exactly once. A line held low does not create a second request. The request is accepted whatever the state of the enable flip-flops.
- R2: When a non-maskable request is pending at a boundary, it is taken in preference to a maskable request.
- R3: A non-maskable response gives `new_pc` = 0066h, `tstates` = 11 and `ret_pc` = the `cur_pc` sampled at the boundary, with `resp_nmi` = 1. It clears `iff1` and leaves `iff2` unchanged.
- R4: A maskable request (`int_n` low) is accepted only at a boundary where `iff1` = 1. It is refused when the previous instruction was the enable instruction (`prev_op` = FBh with `prev_pfx` not EDh). It is also refused when that instruction was a return form (`prev_pfx` = EDh and `prev_op` matching binary 01xxx101).
- R5: Accepting a maskable request clears both `iff1` and `iff2`.
- R6: Every response, of either kind, raises `r_inc` for exactly the cycle in which `resp_valid` is high.
- R7: When `ack_valid` is low at the boundary, the acknowledge byte is taken as FFh.
- R8: In mode 0 the acknowledge byte is treated as a restart whatever its value. The target is the byte ANDed with 38h (bits 5:3 times 8), and the response costs 13 T-states.
- R9: In mode 1, and for the unused mode value 3, the acknowledge byte is ignored. The target is 0038h and the response costs 13 T-states.
- R10: In mode 2, `vec_rd` is high in the cycle after the boundary, with `vec_addr` = {`i_reg`, acknowledge byte}. The response follows one cycle later with `new_pc` = the `vec_data` present during the `vec_rd` cycle, and it costs 19 T-states.
- R11: `halt_clr` is high with a response if and only if `halt_in` was high at the accepting boundary.
- R12: With the NMOS option enabled (parameter `LD_IR_QUIRK` = 1, the default), `pv_clr` is high with a maskable response when `ld_a_ir` was high at the boundary. It is never high with a non-maskable response.
- R13: After reset, `iff1`, `iff2` and `im_mode` are 0. When no acceptance occurs, `iff_cmd` acts as follows: 1 sets both flip-flops, 2 clears both, 3 copies `iff2` into `iff1`, and 0 keeps them. `im_wr` loads `im_val` into `im_mode`.
- R14: A boundary strobe that arrives during the mode-2 table-read cycle is ignored. A request still pending at that point is kept for a later boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| nmi_n | input | 1 | Non-maskable request, active low, edge sensitive |
| int_n | input | 1 | Maskable request, active low, level sensitive |
| boundary | input | 1 | One-cycle instruction-boundary strobe |
| halt_in | input | 1 | Core is in the HALT state |
| ld_a_ir | input | 1 | Current instruction is a load of A from I or R |
| prev_pfx | input | 8 | Prefix byte of the previous instruction (00h if none) |
| prev_op | input | 8 | Opcode byte of the previous instruction |
| i_reg | input | 8 | Interrupt vector base register |
| ack_valid | input | 1 | A device drives the acknowledge byte |
| ack_data | input | 8 | Acknowledge byte |
| cur_pc | input | 16 | Program counter at the boundary |
| iff_cmd | input | 2 | Enable flip-flop command: 0 keep, 1 set, 2 clear, 3 restore |
| im_wr | input | 1 | Load interrupt mode |
| im_val | input | 2 | New interrupt mode |
| vec_data | input | 16 | Table word returned during the `vec_rd` cycle |
| iff1 | output | 1 | Enable flip-flop 1 |
| iff2 | output | 1 | Enable flip-flop 2 |
| im_mode | output | 2 | Current interrupt mode |
| vec_rd | output | 1 | Mode-2 table read request |
| vec_addr | output | 16 | Mode-2 table address |
| resp_valid | output | 1 | Response pulse |
| resp_nmi | output | 1 | Response is non-maskable |
| new_pc | output | 16 | Jump target and MEMPTR value |
| ret_pc | output | 16 | Return address to push |
| tstates | output | 5 | T-states charged for the response |
| r_inc | output | 1 | Refresh counter increment |
| halt_clr | output | 1 | Leave the HALT state |
| pv_clr | output | 1 | Clear the parity/overflow flag |

## Verification
The bench goes after the instructions that block a maskable request. A decoder that matched the enable opcode without checking the prefix would refuse a prefixed FBh byte. One that missed a return form would accept an interrupt the core is not ready for. It drives a non-maskable edge in the same cycle as an accepting boundary, and then a boundary during the table read: a design that lost the pending edge, or that acted on the busy-cycle strobe, would give no non-maskable response or a response at the wrong time. It also checks the absent-byte default in modes 0 and 2, non-restart bytes in mode 0, and that `iff2` survives a non-maskable response so that the restore command brings `iff1` back.

// File: rtl/irq_seq_pkg.sv
package irq_seq_pkg;
  localparam logic [7:0] OP_EI     = 8'hFB;
  localparam logic [7:0] PFX_ED    = 8'hED;
  localparam logic [7:0] ACK_FLOAT = 8'hFF;
  localparam logic [7:0] RST_MASK  = 8'h38;

  localparam int TS_NMI  = 11;
  localparam int TS_RST  = 13;
  localparam int TS_TBL  = 19;
  localparam int NMI_TGT = 16'h0066;
  localparam int IM1_TGT = 16'h0038;

  typedef enum logic [1:0] {
    IFF_KEEP    = 2'd0,
    IFF_SET     = 2'd1,
    IFF_CLR     = 2'd2,
    IFF_RESTORE = 2'd3
  } iff_cmd_e;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_NMI  = 2'd1,
    SEL_INT  = 2'd2
  } sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_TBL  = 1'b1
  } st_e;
endpackage

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic taken,
  output logic pending
);
  logic line_q, line_d;
  logic pend_q, pend_d;
  logic fall;

  always_comb begin
    fall   = line_q & ~nmi_n;
    line_d = nmi_n;
    // a new edge wins over the clear of the request being taken
    pend_d = fall | (pend_q & ~taken);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= 1'b1;
      pend_q <= 1'b0;
    end else begin
      line_q <= line_d;
      pend_q <= pend_d;
    end
  end

  assign pending = pend_q;
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter
  import irq_seq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              at_boundary,
  input  logic              nmi_pend,
  input  logic              int_n,
  input  logic              iff1,
  input  logic [DATA_W-1:0] prev_pfx,
  input  logic [DATA_W-1:0] prev_op,
  output sel_e              sel
);
  logic after_ei;
  logic after_ret;
  logic int_ok;

  always_comb begin
    after_ei  = (prev_op == OP_EI) && (prev_pfx != PFX_ED);
    after_ret = (prev_pfx == PFX_ED) && (prev_op[7:6] == 2'b01) &&
                (prev_op[2:0] == 3'b101);
    int_ok    = ~int_n & iff1 & ~after_ei & ~after_ret;
    sel = SEL_NONE;
    if (at_boundary) begin
      if (nmi_pend)    sel = SEL_NMI;
      else if (int_ok) sel = SEL_INT;
    end
  end
endmodule

// File: rtl/irq_iff_regs.sv
module irq_iff_regs
  import irq_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  iff_cmd_e   cmd,
  input  logic       take_nmi,
  input  logic       take_int,
  input  logic       im_wr,
  input  logic [1:0] im_val,
  output logic       iff1,
  output logic       iff2,
  output logic [1:0] im
);
  logic       iff1_q, iff1_d;
  logic       iff2_q, iff2_d;
  logic [1:0] im_q, im_d;

  always_comb begin
    iff1_d = iff1_q;
    iff2_d = iff2_q;
    im_d   = im_q;
    if (take_int) begin
      iff1_d = 1'b0;
      iff2_d = 1'b0;
    end else if (take_nmi) begin
      iff1_d = 1'b0;
    end else begin
      case (cmd)
        IFF_SET:     begin iff1_d = 1'b1; iff2_d = 1'b1; end
        IFF_CLR:     begin iff1_d = 1'b0; iff2_d = 1'b0; end
        IFF_RESTORE: iff1_d = iff2_q;
        default:     ;
      endcase
    end
    if (im_wr) im_d = im_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iff1_q <= 1'b0;
      iff2_q <= 1'b0;
      im_q   <= 2'd0;
    end else begin
      iff1_q <= iff1_d;
      iff2_q <= iff2_d;
      im_q   <= im_d;
    end
  end

  assign iff1 = iff1_q;
  assign iff2 = iff2_q;
  assign im   = im_q;
endmodule

// File: rtl/irq_target.sv
module irq_target
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int TS_W   = 5
) (
  input  logic [1:0]        im,
  input  logic [DATA_W-1:0] ack_byte,
  output logic [ADDR_W-1:0] target,
  output logic [TS_W-1:0]   cost,
  output logic              use_table
);
  always_comb begin
    use_table = 1'b0;
    cost      = TS_W'(TS_RST);
    target    = ADDR_W'(IM1_TGT);
    case (im)
      2'd0: target = ADDR_W'(ack_byte & RST_MASK);
      2'd2: begin
        use_table = 1'b1;
        cost      = TS_W'(TS_TBL);
        target    = '0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_seq_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int TS_W        = 5,
  parameter bit LD_IR_QUIRK = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_n,
  input  logic              int_n,
  input  logic              boundary,
  input  logic              halt_in,
  input  logic              ld_a_ir,
  input  logic [DATA_W-1:0] prev_pfx,
  input  logic [DATA_W-1:0] prev_op,
  input  logic [DATA_W-1:0] i_reg,
  input  logic              ack_valid,
  input  logic [DATA_W-1:0] ack_data,
  input  logic [ADDR_W-1:0] cur_pc,
  input  logic [1:0]        iff_cmd,
  input  logic              im_wr,
  input  logic [1:0]        im_val,
  input  logic [ADDR_W-1:0] vec_data,
  output logic              iff1,
  output logic              iff2,
  output logic [1:0]        im_mode,
  output logic              vec_rd,
  output logic [ADDR_W-1:0] vec_addr,
  output logic              resp_valid,
  output logic              resp_nmi,
  output logic [ADDR_W-1:0] new_pc,
  output logic [ADDR_W-1:0] ret_pc,
  output logic [TS_W-1:0]   tstates,
  output logic              r_inc,
  output logic              halt_clr,
  output logic              pv_clr
);
  localparam int PTR_W = 2 * DATA_W;

  st_e               st_q, st_d;
  sel_e              sel;
  logic              nmi_pend;
  logic              at_bnd;
  logic              take_nmi, take_int;
  logic [DATA_W-1:0] ack_byte;
  logic [ADDR_W-1:0] tgt;
  logic [TS_W-1:0]   cost;
  logic              use_tbl;
  logic              pv_req;

  // held across the table-read cycle
  logic [ADDR_W-1:0] hold_ret_q, hold_ret_d;
  logic              hold_halt_q, hold_halt_d;
  logic              hold_pv_q, hold_pv_d;
  logic [ADDR_W-1:0] vaddr_q, vaddr_d;

  // response registers
  logic              rv_q, rv_d;
  logic              rn_q, rn_d;
  logic [ADDR_W-1:0] npc_q, npc_d;
  logic [ADDR_W-1:0] rpc_q, rpc_d;
  logic [TS_W-1:0]   ts_q, ts_d;
  logic              ri_q, ri_d;
  logic              hc_q, hc_d;
  logic              pc_q, pc_d;

  assign at_bnd   = boundary & (st_q == ST_IDLE);
  assign ack_byte = ack_valid ? ack_data : ACK_FLOAT;
  assign take_nmi = (sel == SEL_NMI);
  assign take_int = (sel == SEL_INT);

  generate
    if (LD_IR_QUIRK) begin : g_pv_on
      assign pv_req = ld_a_ir;
    end else begin : g_pv_off
      assign pv_req = 1'b0;
    end
  endgenerate

  irq_nmi_latch u_nmi (
    .clk     (clk),
    .rst_n   (rst_n),
    .nmi_n   (nmi_n),
    .taken   (take_nmi),
    .pending (nmi_pend)
  );

  irq_arbiter #(.DATA_W(DATA_W)) u_arb (
    .at_boundary (at_bnd),
    .nmi_pend    (nmi_pend),
    .int_n       (int_n),
    .iff1        (iff1),
    .prev_pfx    (prev_pfx),
    .prev_op     (prev_op),
    .sel         (sel)
  );

  irq_iff_regs u_iff (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd      (iff_cmd_e'(iff_cmd)),
    .take_nmi (take_nmi),
    .take_int (take_int),
    .im_wr    (im_wr),
    .im_val   (im_val),
    .iff1     (iff1),
    .iff2     (iff2),
    .im       (im_mode)
  );

  irq_target #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TS_W(TS_W)) u_tgt (
    .im        (im_mode),
    .ack_byte  (ack_byte),
    .target    (tgt),
    .cost      (cost),
    .use_table (use_tbl)
  );

  always_comb begin
    st_d        = st_q;
    hold_ret_d  = hold_ret_q;
    hold_halt_d = hold_halt_q;
    hold_pv_d   = hold_pv_q;
    vaddr_d     = vaddr_q;
    rv_d  = 1'b0;
    rn_d  = 1'b0;
    npc_d = npc_q;
    rpc_d = rpc_q;
    ts_d  = ts_q;
    ri_d  = 1'b0;
    hc_d  = 1'b0;
    pc_d  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (take_nmi) begin
          rv_d  = 1'b1;
          rn_d  = 1'b1;
          npc_d = ADDR_W'(NMI_TGT);
          rpc_d = cur_pc;
          ts_d  = TS_W'(TS_NMI);
          ri_d  = 1'b1;
          hc_d  = halt_in;
        end else if (take_int && !use_tbl) begin
          rv_d  = 1'b1;
          npc_d = tgt;
          rpc_d = cur_pc;
          ts_d  = cost;
          ri_d  = 1'b1;
          hc_d  = halt_in;
          pc_d  = pv_req;
        end else if (take_int) begin
          st_d        = ST_TBL;
          hold_ret_d  = cur_pc;
          hold_halt_d = halt_in;
          hold_pv_d   = pv_req;
          vaddr_d     = ADDR_W'(PTR_W'({i_reg, ack_byte}));
        end
      end
      ST_TBL: begin
        st_d  = ST_IDLE;
        rv_d  = 1'b1;
        npc_d = vec_data;
        rpc_d = hold_ret_q;
        ts_d  = TS_W'(TS_TBL);
        ri_d  = 1'b1;
        hc_d  = hold_halt_q;
        pc_d  = hold_pv_q;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      hold_ret_q  <= '0;
      hold_halt_q <= 1'b0;
      hold_pv_q   <= 1'b0;
      vaddr_q     <= '0;
      rv_q  <= 1'b0;
      rn_q  <= 1'b0;
      npc_q <= '0;
      rpc_q <= '0;
      ts_q  <= '0;
      ri_q  <= 1'b0;
      hc_q  <= 1'b0;
      pc_q  <= 1'b0;
    end else begin
      st_q        <= st_d;
      hold_ret_q  <= hold_ret_d;
      hold_halt_q <= hold_halt_d;
      hold_pv_q   <= hold_pv_d;
      vaddr_q     <= vaddr_d;
      rv_q  <= rv_d;
      rn_q  <= rn_d;
      npc_q <= npc_d;
      rpc_q <= rpc_d;
      ts_q  <= ts_d;
      ri_q  <= ri_d;
      hc_q  <= hc_d;
      pc_q  <= pc_d;
    end
  end

  assign vec_rd     = (st_q == ST_TBL);
  assign vec_addr   = vaddr_q;
  assign resp_valid = rv_q;
  assign resp_nmi   = rn_q;
  assign new_pc     = npc_q;
  assign ret_pc     = rpc_q;
  assign tstates    = ts_q;
  assign r_inc      = ri_q;
  assign halt_clr   = hc_q;
  assign pv_clr     = pc_q;
endmodule

// File: rtl/irq_ack_seq_chk.sv
module irq_ack_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        iff1,
  input logic        iff2,
  input logic        vec_rd,
  input logic [15:0] vec_data,
  input logic        resp_valid,
  input logic        resp_nmi,
  input logic [15:0] new_pc,
  input logic [4:0]  tstates,
  input logic        r_inc,
  input logic        halt_clr,
  input logic        pv_clr
);
  assert_nmi_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && resp_nmi |-> new_pc == 16'h0066 && tstates == 5'd11 && !iff1);

  assert_int_clears_iff_R5: assert property (@(posedge clk) disable iff (!rst_n)
    resp_valid && !resp_nmi |-> !iff1 && !iff2);

  assert_table_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |=> resp_valid && !resp_nmi && tstates == 5'd19 && new_pc == $past(vec_data));

  assert_single_tbl_cycle_R14: assert property (@(posedge clk) disable iff (!rst_n)
    vec_rd |=> !vec_rd);

  assert_refresh_R6: assert property (@(posedge clk) disable iff (!rst_n)
    r_inc |-> resp_valid);

  assert_halt_exit_R11: assert property (@(posedge clk) disable iff (!rst_n)
    halt_clr |-> resp_valid);

  assert_pv_int_only_R12: assert property (@(posedge clk) disable iff (!rst_n)
    pv_clr |-> resp_valid && !resp_nmi);
endmodule

bind irq_ack_seq irq_ack_seq_chk u_chk (.*);

// File: tb/irq_ack_seq_tb.sv
module irq_ack_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi_n, int_n, boundary, halt_in, ld_a_ir;
  logic [7:0]  prev_pfx, prev_op, i_reg, ack_data;
  logic        ack_valid;
  logic [15:0] cur_pc, vec_data;
  logic [1:0]  iff_cmd;
  logic        im_wr;
  logic [1:0]  im_val;
  logic        iff1, iff2, vec_rd, resp_valid, resp_nmi, r_inc, halt_clr, pv_clr;
  logic [1:0]  im_mode;
  logic [15:0] vec_addr, new_pc, ret_pc;
  logic [4:0]  tstates;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  irq_ack_seq u_dut (.*);

  typedef struct packed {
    logic [1:0]  mode;
    logic        intn;
    logic [7:0]  pfx;
    logic [7:0]  op;
    logic        av;
    logic [7:0]  ad;
    logic [7:0]  ir;
    logic [15:0] vd;
    logic        acc;
    logic [15:0] pc;
    logic [4:0]  ts;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b0, 8'h00, 8'h00, 1'b1, 8'h12, 8'h00, 16'h0000, 1'b1, 16'h0038, 5'd13}, // R9
    '{2'd0, 1'b0, 8'h00, 8'h00, 1'b1, 8'hD7, 8'h00, 16'h0000, 1'b1, 16'h0010, 5'd13}, // R8
    '{2'd0, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 8'h00, 16'h0000, 1'b1, 16'h0038, 5'd13}, // R7
    '{2'd0, 1'b0, 8'h00, 8'h00, 1'b1, 8'h45, 8'h00, 16'h0000, 1'b1, 16'h0000, 5'd13}, // R8
    '{2'd2, 1'b0, 8'h00, 8'h00, 1'b1, 8'h20, 8'h80, 16'h1234, 1'b1, 16'h1234, 5'd19}, // R10
    '{2'd2, 1'b0, 8'h00, 8'h00, 1'b0, 8'h00, 8'h3C, 16'hABCD, 1'b1, 16'hABCD, 5'd19}, // R10 R7
    '{2'd1, 1'b0, 8'h00, 8'hFB, 1'b1, 8'h00, 8'h00, 16'h0000, 1'b0, 16'h0000, 5'd0 }, // R4
    '{2'd1, 1'b0, 8'hED, 8'h4D, 1'b1, 8'h00, 8'h00, 16'h0000, 1'b0, 16'h0000, 5'd0 }, // R4
    '{2'd1, 1'b0, 8'hED, 8'h75, 1'b1, 8'h00, 8'h00, 16'h0000, 1'b0, 16'h0000, 5'd0 }, // R4
    '{2'd1, 1'b0, 8'hED, 8'hFB, 1'b1, 8'h00, 8'h00, 16'h0000, 1'b1, 16'h0038, 5'd13}, // R4
    '{2'd1, 1'b1, 8'h00, 8'h00, 1'b1, 8'h00, 8'h00, 16'h0000, 1'b0, 16'h0000, 5'd0 }, // R4
    '{2'd3, 1'b0, 8'h00, 8'h00, 1'b1, 8'hC7, 8'h00, 16'h0000, 1'b1, 16'h0038, 5'd13}  // R9
  };

  task automatic chk(input logic ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cmd_iff(input logic [1:0] c);
    @(negedge clk);
    iff_cmd = c;
    @(negedge clk);
    iff_cmd = 2'd0;
  endtask

  task automatic set_mode(input logic [1:0] m);
    @(negedge clk);
    im_wr = 1'b1; im_val = m;
    @(negedge clk);
    im_wr = 1'b0;
  endtask

  // strobe a boundary; returns at the negedge after the accepting edge
  task automatic strobe;
    @(negedge clk);
    boundary = 1'b1;
    @(negedge clk);
    boundary = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; nmi_n = 1'b1; int_n = 1'b1; boundary = 1'b0; halt_in = 1'b0;
    ld_a_ir = 1'b0; prev_pfx = 8'h00; prev_op = 8'h00; i_reg = 8'h00;
    ack_valid = 1'b0; ack_data = 8'h00; cur_pc = 16'h0000; vec_data = 16'h0000;
    iff_cmd = 2'd0; im_wr = 1'b0; im_val = 2'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R13 reset state
    chk(iff1 == 0 && iff2 == 0, "R13 reset iff", {iff1, iff2}, 0);
    chk(im_mode == 0, "R13 reset im", im_mode, 0);
    chk(resp_valid == 0 && vec_rd == 0, "R13 reset outputs", {resp_valid, vec_rd}, 0);

    // table-driven maskable tests
    for (int k = 0; k < NV; k++) begin
      cmd_iff(2'd1);
      set_mode(VECS[k].mode);
      @(negedge clk);
      int_n = VECS[k].intn; prev_pfx = VECS[k].pfx; prev_op = VECS[k].op;
      ack_valid = VECS[k].av; ack_data = VECS[k].ad; i_reg = VECS[k].ir;
      cur_pc = 16'h1000 + 16'(k);
      strobe();
      if (VECS[k].acc && VECS[k].mode == 2'd2) begin
        chk(vec_rd == 1 && resp_valid == 0, "R10 table read", {vec_rd, resp_valid}, 2);
        chk(vec_addr == {VECS[k].ir, VECS[k].av ? VECS[k].ad : 8'hFF},
            "R10 R7 table address", vec_addr, {VECS[k].ir, VECS[k].av ? VECS[k].ad : 8'hFF});
        vec_data = VECS[k].vd;
        @(negedge clk);
      end
      if (VECS[k].acc) begin
        chk(resp_valid == 1 && resp_nmi == 0, "R4 accepted", {resp_valid, resp_nmi}, 2);
        chk(new_pc == VECS[k].pc, "R8 R9 R10 target", new_pc, VECS[k].pc);
        chk(tstates == VECS[k].ts, "R8 R9 R10 tstates", tstates, VECS[k].ts);
        chk(ret_pc == 16'h1000 + 16'(k), "R3 return pc", ret_pc, 16'h1000 + 16'(k));
        chk(r_inc == 1 && halt_clr == 0 && pv_clr == 0, "R6 R11 R12 strobes",
            {r_inc, halt_clr, pv_clr}, 4);
        chk(iff1 == 0 && iff2 == 0, "R5 iffs cleared", {iff1, iff2}, 0);
      end else begin
        chk(resp_valid == 0 && vec_rd == 0, "R4 refused", {resp_valid, vec_rd}, 0);
        @(negedge clk);
        chk(resp_valid == 0 && vec_rd == 0, "R4 refused later", {resp_valid, vec_rd}, 0);
        chk(iff1 == 1, "R4 iff kept", iff1, 1);
      end
      int_n = 1'b1; prev_pfx = 8'h00; prev_op = 8'h00;
    end

    // R1 R3 non-maskable with iffs clear
    cmd_iff(2'd2);
    @(negedge clk);
    nmi_n = 1'b0; cur_pc = 16'h4321;
    repeat (2) @(negedge clk);
    strobe();
    chk(resp_valid && resp_nmi, "R1 nmi accepted", {resp_valid, resp_nmi}, 3);
    chk(new_pc == 16'h0066 && tstates == 11, "R3 nmi target", {new_pc, 11'(tstates)}, {16'h0066, 11'd11});
    chk(ret_pc == 16'h4321 && r_inc, "R3 R6 nmi return", ret_pc, 16'h4321);
    strobe();
    chk(resp_valid == 0, "R1 held low once", resp_valid, 0);
    nmi_n = 1'b1;

    // R2 priority, R3 iff2 kept, R13 restore
    cmd_iff(2'd1);
    set_mode(2'd1);
    @(negedge clk);
    nmi_n = 1'b0; int_n = 1'b0; ld_a_ir = 1'b1; halt_in = 1'b1;
    @(negedge clk);
    strobe();
    chk(resp_valid && resp_nmi, "R2 nmi wins", {resp_valid, resp_nmi}, 3);
    chk(iff1 == 0 && iff2 == 1, "R3 iff2 kept", {iff1, iff2}, 1);
    chk(pv_clr == 0 && halt_clr == 1, "R12 R11 nmi strobes", {pv_clr, halt_clr}, 1);
    nmi_n = 1'b1;
    strobe();
    chk(resp_valid == 0, "R4 iff1 low blocks", resp_valid, 0);
    cmd_iff(2'd3);
    chk(iff1 == 1 && iff2 == 1, "R13 restore", {iff1, iff2}, 3);
    strobe();
    chk(resp_valid && !resp_nmi, "R4 int after restore", {resp_valid, resp_nmi}, 2);
    chk(pv_clr == 1 && halt_clr == 1, "R12 R11 int strobes", {pv_clr, halt_clr}, 3);
    ld_a_ir = 1'b0; halt_in = 1'b0; int_n = 1'b1;

    // R14 boundary during table read, with an edge landing at acceptance
    cmd_iff(2'd1);
    set_mode(2'd2);
    @(negedge clk);
    int_n = 1'b0; ack_valid = 1'b1; ack_data = 8'h10; i_reg = 8'h22;
    boundary = 1'b1; nmi_n = 1'b0;
    @(negedge clk);
    chk(vec_rd == 1, "R14 table cycle", vec_rd, 1);
    vec_data = 16'h5A5A;
    @(negedge clk);
    boundary = 1'b0;
    chk(resp_valid && !resp_nmi && new_pc == 16'h5A5A, "R14 busy strobe ignored",
        {resp_valid, resp_nmi}, 2);
    @(negedge clk);
    chk(resp_valid == 0, "R14 no extra response", resp_valid, 0);
    int_n = 1'b1;
    strobe();
    chk(resp_valid && resp_nmi, "R1 pending kept", {resp_valid, resp_nmi}, 3);
    nmi_n = 1'b1;

    // R13 clear
    cmd_iff(2'd1);
    cmd_iff(2'd2);
    chk(iff1 == 0 && iff2 == 0, "R13 clear", {iff1, iff2}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule